// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing frames from memory to a byte stream. Software builds a ring of descriptors in memory and pulses a start request. From then on the engine owns each descriptor whose valid flag is set. For each one it fetches the control word, the buffer length and the buffer address. It then reads the buffer word by word and presents its bytes on an 8-bit stream with valid, ready and last. At the end it writes a status word back into the descriptor, which clears the valid flag and returns ownership to software.

Each descriptor is four 32-bit words at a 16-byte stride from a base address. Word 0 carries control and status. Word 1 holds the byte length in bits 15:0. Word 2 holds the buffer byte address. Word 3 is not read. The engine halts by itself on a descriptor whose valid flag is clear. Software can also ask it to stop after the current write-back. If the sink holds the stream off for too long, the frame is aborted and that outcome is reported in the write-back.

Top module: `txdesc_dma`

## Requirements
- R1: After reset `running` is 0. A one-cycle `go_set` pulse while idle sets `running` on the next edge. The first start after reset fetches the descriptor at `ring_base`.
- R2: A fetched word 0 with bit 31 at 0 clears `running`. No byte is sent and nothing is written to memory. While `running` is 0 there is no memory request and no stream valid.
- R3: Buffer bytes leave in ascending address order from the word 2 address, which need not be aligned. The byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the 32-bit word at A with its two low bits cleared.
- R4: Exactly (word 1 bits 15:0) bytes are sent, and `tx_last` is high only on the final one. A memory request holds its address and direction until `mem_ack`.
- R5: Write-back stores a new word 0 with bit 31 at 0 and bits 30:28 as fetched. Bits 27:2 are 0, bit 0 is 1 on normal completion and bit 1 is 1 on abort, and exactly one of bits 1:0 is set.
- R6: A descriptor with length 0 sends no byte and is still written back with status bit 0 set.
- R7: If `tx_valid` stays high with `tx_ready` low for `stall_limit`+1 consecutive cycles, the frame is aborted. `tx_valid` drops and the write-back reports bit 1 set and bit 0 clear.
- R8: After a write-back the next descriptor is 16 bytes further on. If word 0 bit 30 was set, the next descriptor is at `ring_base`.
- R9: A `go_set` pulse while `running` is 1 has no effect on the frames sent or the descriptors written.
- R10: A `go_clr` pulse while running stops the engine after the current descriptor's write-back and leaves the following descriptor untouched. A later `go_set` resumes at that following descriptor.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold their values unless valid drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Stop-after-current request pulse |
| ring_base | input | AW | Byte address of the first descriptor |
| stall_limit | input | TW | Allowed consecutive sink hold-off cycles before abort |
| running | output | 1 | Engine active (start bit state) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the 32-bit word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench uses the defaults AW=16, LW=16 and TW=8. A 4 KB memory model holds both the descriptor rings and the buffers, so unaligned buffers and wrapped rings sit in the same small space. `stall_limit` is set at run time to 5 or 3. This lets the abort path finish within a few cycles, while an alternating ready pattern stays below the limit. A 16-bit length field and 8-bit limit still allow 20-byte frames and mid-frame stop and restart requests.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CTL,
        S_RD_LEN,
        S_RD_ADR,
        S_RD_DATA,
        S_SEND,
        S_WB
    } txd_state_e;

    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int DESC_BYTES = 16;

    localparam logic [1:0] FLD_CTL = 2'd0;
    localparam logic [1:0] FLD_LEN = 2'd1;
    localparam logic [1:0] FLD_ADR = 2'd2;

endpackage

// File: rtl/txd_ring_step.sv
module txd_ring_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          wrap,
    input  logic [1:0]    fld,
    output logic [AW-1:0] fld_addr,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STRIDE = AW'(txd_pkg::DESC_BYTES);

    // word offset inside the current descriptor
    assign fld_addr = cur + {{(AW-4){1'b0}}, fld, 2'b00};
    // following descriptor, or back to the ring start
    assign nxt      = wrap ? base : cur + STRIDE;
endmodule

// File: rtl/txd_lane_sel.sv
module txd_lane_sel #(
    parameter int WW = 32
) (
    input  logic [WW-1:0]              word,
    input  logic [$clog2(WW/8)-1:0]    sel,
    output logic [7:0]                 lane
);
    localparam int LANES = WW / 8;

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/txd_stall_timer.sv
module txd_stall_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stalled,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] ONE_T = TW'(1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (stalled) begin
            cnt_d = (cnt_q == limit) ? cnt_q : cnt_q + ONE_T;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = stalled && (cnt_q == limit);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txd_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_set,
    input  logic          go_clr,
    input  logic [AW-1:0] ring_base,
    input  logic [TW-1:0] stall_limit,
    output logic          running,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);
    localparam logic [LW-1:0] ONE_L = LW'(1);
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam int            SW    = $clog2(WORD_W / 8);

    typedef struct packed {
        txd_state_e      st;
        logic            run;
        logic            stop;
        logic            use_base;
        logic [AW-1:0]   ptr;
        logic [2:0]      ctl;
        logic [LW-1:0]   left;
        logic [AW-1:0]   baddr;
        logic [31:0]     word;
        logic            abort;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]    fld;
    logic [AW-1:0] fld_addr;
    logic [AW-1:0] nxt_ptr;
    logic          stalled;
    logic          stall_expire;
    logic [7:0]    lane_byte;
    logic [31:0]   wb_word;

    txd_ring_step #(.AW(AW)) ring_i (
        .cur      (r_q.ptr),
        .base     (ring_base),
        .wrap     (r_q.ctl[2]),
        .fld      (fld),
        .fld_addr (fld_addr),
        .nxt      (nxt_ptr)
    );

    txd_lane_sel #(.WW(WORD_W)) lane_i (
        .word (r_q.word),
        .sel  (r_q.baddr[SW-1:0]),
        .lane (lane_byte)
    );

    txd_stall_timer #(.TW(TW)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stalled (stalled),
        .limit   (stall_limit),
        .expire  (stall_expire)
    );

    assign stalled = tx_valid && !tx_ready;
    // keep the configuration nibble, hand ownership back, report outcome
    assign wb_word = {1'b0, r_q.ctl, 26'd0, r_q.abort, ~r_q.abort};

    always_comb begin
        r_d       = r_q;
        fld       = FLD_CTL;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;

        if (r_q.run && go_clr) r_d.stop = 1'b1;

        unique case (r_q.st)
            S_IDLE: begin
                if (go_set && !go_clr) begin
                    r_d.run  = 1'b1;
                    r_d.stop = 1'b0;
                    r_d.st   = S_RD_CTL;
                    if (r_q.use_base) begin
                        r_d.ptr      = ring_base;
                        r_d.use_base = 1'b0;
                    end
                end
            end
            S_RD_CTL: begin
                fld      = FLD_CTL;
                mem_req  = 1'b1;
                mem_addr = fld_addr;
                if (mem_ack) begin
                    if (!mem_rdata[OWN_BIT]) begin
                        r_d.run  = 1'b0;
                        r_d.stop = 1'b0;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.ctl = mem_rdata[30:28];
                        r_d.st  = S_RD_LEN;
                    end
                end
            end
            S_RD_LEN: begin
                fld      = FLD_LEN;
                mem_req  = 1'b1;
                mem_addr = fld_addr;
                if (mem_ack) begin
                    r_d.left = mem_rdata[LW-1:0];
                    r_d.st   = S_RD_ADR;
                end
            end
            S_RD_ADR: begin
                fld      = FLD_ADR;
                mem_req  = 1'b1;
                mem_addr = fld_addr;
                if (mem_ack) begin
                    r_d.baddr = mem_rdata[AW-1:0];
                    r_d.abort = 1'b0;
                    r_d.st    = (r_q.left == '0) ? S_WB : S_RD_DATA;
                end
            end
            S_RD_DATA: begin
                mem_req  = 1'b1;
                mem_addr = {r_q.baddr[AW-1:SW], {SW{1'b0}}};
                if (mem_ack) begin
                    r_d.word = mem_rdata;
                    r_d.st   = S_SEND;
                end
            end
            S_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    r_d.left  = r_q.left - ONE_L;
                    r_d.baddr = r_q.baddr + ONE_A;
                    if (r_q.left == ONE_L)
                        r_d.st = S_WB;
                    else if (&r_q.baddr[SW-1:0])
                        r_d.st = S_RD_DATA;
                end else if (stall_expire) begin
                    r_d.abort = 1'b1;
                    r_d.st    = S_WB;
                end
            end
            S_WB: begin
                fld       = FLD_CTL;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fld_addr;
                mem_wdata = wb_word;
                if (mem_ack) begin
                    r_d.ptr = nxt_ptr;
                    if (r_q.stop || go_clr) begin
                        r_d.run  = 1'b0;
                        r_d.stop = 1'b0;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st = S_RD_CTL;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= S_IDLE;
            r_q.use_base <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign running = r_q.run;
    assign tx_data = lane_byte;
    assign tx_last = tx_valid && (r_q.left == ONE_L);
endmodule

// File: rtl/txd_checker.sv
module txd_checker #(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go_set,
    input logic          running,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready,
    input logic [TW-1:0] stall_limit
);
    logic [TW:0] stall_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stall_run <= '0;
        else if (tx_valid && !tx_ready)
            stall_run <= (&stall_run) ? stall_run : stall_run + 1'b1;
        else
            stall_run <= '0;
    end

    a_r1_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(go_set));

    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!tx_valid && !mem_req));

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r4_last_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    a_r5_writeback_form: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!mem_wdata[31] && mem_wdata[27:2] == '0
                                  && $countones(mem_wdata[1:0]) == 1));

    a_r7_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> (stall_run <= {1'b0, stall_limit}));

    a_r7_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && stall_run == {1'b0, stall_limit}) |=> !tx_valid);

    a_r11_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_data) && $stable(tx_last))));
endmodule

bind txdesc_dma txd_checker #(.AW(AW), .TW(TW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_set      (go_set),
    .running     (running),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .tx_ready    (tx_ready),
    .stall_limit (stall_limit)
);

// File: tb/txdesc_dma_tb_top.sv
module txdesc_dma_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int LW   = 16;
    localparam int TW   = 8;
    localparam int MEMW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go_set = 1'b0;
    logic          go_clr = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [TW-1:0] stall_limit = '0;
    logic          running;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack_q = 1'b0;
    logic [31:0]   rdata_q = '0;
    logic          tx_valid, tx_data_last;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b0;

    logic [31:0] mem [0:MEMW-1];
    logic [7:0]  cap_b [0:511];
    logic        cap_l [0:511];
    int cap_n = 0, wb_n = 0, vcyc = 0, rdy_mode = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_dma #(.AW(AW), .LW(LW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_set(go_set), .go_clr(go_clr),
        .ring_base(ring_base), .stall_limit(stall_limit), .running(running),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack_q), .mem_rdata(rdata_q),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_data_last),
        .tx_ready(tx_ready)
    );

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack_q <= 1'b0;
        end else if (mem_req && !mem_ack_q) begin
            mem_ack_q <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                wb_n = wb_n + 1;
            end else begin
                rdata_q <= mem[mem_addr[11:2]];
            end
        end else begin
            mem_ack_q <= 1'b0;
        end
    end

    // stream sink capture
    always @(posedge clk) begin
        if (rst_n && tx_valid) vcyc = vcyc + 1;
        if (rst_n && tx_valid && tx_ready && cap_n < 512) begin
            cap_b[cap_n] = tx_data;
            cap_l[cap_n] = tx_data_last;
            cap_n = cap_n + 1;
        end
    end

    always @(negedge clk) begin
        case (rdy_mode)
            0:       tx_ready <= 1'b1;
            1:       tx_ready <= ~tx_ready;
            default: tx_ready <= 1'b0;
        endcase
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic put_desc(int a, logic [31:0] w0, int len, int bufa);
        mem[a >> 2]       = w0;
        mem[(a >> 2) + 1] = 32'(len);
        mem[(a >> 2) + 2] = 32'(bufa);
        mem[(a >> 2) + 3] = 32'h0;
    endtask

    task automatic do_reset(int base, int limit, int mode);
        @(negedge clk);
        rst_n       = 1'b0;
        ring_base   = AW'(base);
        stall_limit = TW'(limit);
        rdy_mode    = mode;
        for (int i = 0; i < MEMW; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        cap_n = 0; wb_n = 0; vcyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); go_set = 1'b1;
        @(negedge clk); go_set = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (running && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " engine halts"}, 32'(running), 32'd0);
    endtask

    task automatic check_bytes(string tag, int first, int bufa, int len);
        for (int k = 0; k < len; k++) begin
            chk({tag, " byte"}, 32'(cap_b[first+k]), 32'(pat(bufa + k)));
            chk({tag, " last"}, 32'(cap_l[first+k]), 32'(k == len - 1));
        end
    endtask

    task automatic t_reset();
        do_reset(32'h100, 255, 0);
        chk("R1 running after reset", 32'(running), 32'd0);
        chk("R2 no valid after reset", 32'(tx_valid), 32'd0);
        chk("R2 no request after reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_single();
        do_reset(32'h100, 255, 0);
        put_desc(32'h100, 32'hC000_0000, 6, 32'h803);
        put_desc(32'h110, 32'h8000_0000, 3, 32'h900);
        kick();
        chk("R1 running after start", 32'(running), 32'd1);
        wait_done("R8");
        chk("R4 byte count", 32'(cap_n), 32'd6);
        check_bytes("R3 R4 unaligned frame", 0, 32'h803, 6);
        chk("R5 writeback word", mem[32'h100 >> 2], 32'h4000_0001);
        chk("R8 wrap skips next entry", mem[32'h110 >> 2], 32'h8000_0000);
        chk("R8 one writeback", 32'(wb_n), 32'd1);
    endtask

    task automatic t_invalid();
        do_reset(32'h200, 255, 0);
        put_desc(32'h200, 32'h4000_0000, 5, 32'h800);
        kick();
        wait_done("R2");
        chk("R2 no bytes", 32'(cap_n), 32'd0);
        chk("R2 no writes", 32'(wb_n), 32'd0);
        chk("R2 descriptor untouched", mem[32'h200 >> 2], 32'h4000_0000);
    endtask

    task automatic t_chain();
        do_reset(32'h100, 3, 1);
        put_desc(32'h100, 32'h8000_0000, 9, 32'h801);
        put_desc(32'h110, 32'h8000_0000, 4, 32'h840);
        put_desc(32'h120, 32'h0000_0000, 7, 32'h860);
        kick();
        wait_done("R8");
        chk("R8 chained byte count", 32'(cap_n), 32'd13);
        check_bytes("R3 chain first", 0, 32'h801, 9);
        check_bytes("R3 chain second", 9, 32'h840, 4);
        chk("R5 first writeback", mem[32'h100 >> 2], 32'h0000_0001);
        chk("R8 second writeback", mem[32'h110 >> 2], 32'h0000_0001);
        chk("R2 invalid third untouched", mem[32'h120 >> 2], 32'h0000_0000);
        chk("R8 two writebacks", 32'(wb_n), 32'd2);
    endtask

    task automatic t_zero();
        do_reset(32'h100, 255, 0);
        put_desc(32'h100, 32'hC000_0000, 0, 32'h800);
        kick();
        wait_done("R6");
        chk("R6 zero length sends nothing", 32'(cap_n), 32'd0);
        chk("R6 zero length writeback", mem[32'h100 >> 2], 32'h4000_0001);
        chk("R6 one writeback", 32'(wb_n), 32'd1);
    endtask

    task automatic t_stall();
        do_reset(32'h100, 5, 2);
        put_desc(32'h100, 32'hC000_0000, 4, 32'h800);
        kick();
        wait_done("R7");
        chk("R7 nothing accepted", 32'(cap_n), 32'd0);
        chk("R7 valid cycles before abort", 32'(vcyc), 32'd6);
        chk("R7 abort status", mem[32'h100 >> 2], 32'h4000_0002);
    endtask

    task automatic t_restart_ignored();
        do_reset(32'h100, 3, 1);
        put_desc(32'h100, 32'h8000_0000, 20, 32'h800);
        put_desc(32'h110, 32'hC000_0000, 5, 32'h880);
        kick();
        repeat (10) @(negedge clk);
        go_set = 1'b1;
        @(negedge clk);
        go_set = 1'b0;
        wait_done("R9");
        chk("R9 byte count unchanged", 32'(cap_n), 32'd25);
        check_bytes("R9 second frame", 20, 32'h880, 5);
        chk("R9 writebacks unchanged", 32'(wb_n), 32'd2);
    endtask

    task automatic t_stop_resume();
        do_reset(32'h100, 255, 0);
        put_desc(32'h100, 32'h8000_0000, 20, 32'h800);
        put_desc(32'h110, 32'h8000_0000, 3, 32'h8C0);
        put_desc(32'h120, 32'hC000_0000, 2, 32'h8E0);
        kick();
        repeat (5) @(negedge clk);
        go_clr = 1'b1;
        @(negedge clk);
        go_clr = 1'b0;
        wait_done("R10");
        chk("R10 only current frame", 32'(cap_n), 32'd20);
        chk("R10 current written back", mem[32'h100 >> 2], 32'h0000_0001);
        chk("R10 next untouched", mem[32'h110 >> 2], 32'h8000_0000);
        chk("R10 one writeback", 32'(wb_n), 32'd1);
        kick();
        wait_done("R10 resume");
        chk("R10 resumed byte count", 32'(cap_n), 32'd25);
        check_bytes("R10 resumed frame", 20, 32'h8C0, 3);
        chk("R10 resumed writeback", mem[32'h110 >> 2], 32'h0000_0001);
        chk("R10 last entry writeback", mem[32'h120 >> 2], 32'h4000_0001);
        chk("R10 total writebacks", 32'(wb_n), 32'd3);
    endtask

    initial begin : watchdog
        int n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_single();
        t_invalid();
        t_chain();
        t_zero();
        t_stall();
        t_restart_ignored();
        t_stop_resume();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule